// File: doc/BRIEF.md
# Auto-Incrementing Lookup-Table Memory Port

This block is the register-access engine in front of a small on-chip SRAM that holds four 48-word lookup tables of 16-bit words, followed by four table-setup words. The SRAM is one flat space:

- 00h-2Fh hold the first channel's temperature table.
- 30h-5Fh hold the second channel's temperature table.
- 60h-8Fh hold the first channel's numeric table.
- 90h-BFh hold the second channel's numeric table.
- C0h-C3h hold the setup words (step, hysteresis size, length) of those tables.

C3h is the top of memory. Software talks to the block through a command strobe that carries a command byte and a 16-bit word. The serial framing that delivers these commands lives outside the block.

The address command loads a base address and a burst length. Each write command stores one word at a write pointer and then moves the pointer on by one. A read command copies consecutive words, starting at the base address, into an output FIFO. The copy stops when the burst length is used up or when C3h has been sent, whichever comes first.

The FIFO drains through a valid/ready stream. A word is taken on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The internal loader simply pauses when the FIFO is full, so back-pressure never loses a word. A new read command empties the FIFO and restarts the burst.

Top module: `lut_access_engine`

## Requirements
- R1: Command byte 7Ah loads the base address and the write pointer from data bits 7:0, and the burst length from data bits 15:8.
- R2: Command byte 7Ch stores the data word at the write pointer, and the pointer then advances by one.
- R3: A write whose pointer is above C3h changes no stored word, but the pointer still advances.
- R4: The burst-length field has no effect on writes: every write after an address command is stored, whatever length was loaded.
- R5: Command byte 7Dh streams the words at base, base+1, and so on, in order, ending after exactly the burst length.
- R6: A burst also ends after the word at C3h. A base above C3h yields no words.
- R7: A burst length of 0, or of more than 48, is treated as 48.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. No word is lost or repeated under back-pressure.
- R9: A read command empties the FIFO. `out_valid` is low in the cycle after it, and the stream then restarts from the current base address.
- R10: A read burst does not move the write pointer, and it does not move the base address.
- R11: After reset, `out_valid` is low, and it stays low until a read command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_byte | input | 8 | Command byte (7Ah address, 7Ch write, 7Dh read) |
| cmd_data | input | 16 | Command data word |
| out_valid | output | 1 | FIFO head word is valid |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | 16 | FIFO head word |

## Verification
The bench builds the block with a four-word output FIFO instead of the default eight. Bursts of up to 48 words, drained with a consumer that is ready about three cycles in four, then fill the FIFO many times over. This puts the loader's full-FIFO pause and the hold rule under back-pressure under steady load. With the default memory span, random bases and lengths regularly run into C3h, so bursts cut short by the top of memory, and length codes of 0 and above 48, all occur alongside plain bursts.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam logic [7:0] OP_SET_ADDR = 8'h7A;
  localparam logic [7:0] OP_WR_DATA  = 8'h7C;
  localparam logic [7:0] OP_RD_DATA  = 8'h7D;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] base;
  } addr_word_t;
endpackage

// File: rtl/lut_ptr_ctrl.sv
module lut_ptr_ctrl #(
  parameter int AW        = 8,
  parameter int MAX_WORDS = 48,
  localparam int LW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_addr,
  input  logic [7:0]    new_base,
  input  logic [7:0]    new_len,
  input  logic          wr_step,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] wptr_q,
  output logic [LW-1:0] len_q
);
  logic [LW-1:0] len_norm;

  always_comb begin
    if (new_len == 8'd0 || int'(new_len) > MAX_WORDS) len_norm = LW'(MAX_WORDS);
    else                                             len_norm = LW'(new_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wptr_q <= '0;
      len_q  <= LW'(MAX_WORDS);
    end else if (set_addr) begin
      base_q <= AW'(new_base);
      wptr_q <= AW'(new_base);
      len_q  <= len_norm;
    end else if (wr_step) begin
      wptr_q <= wptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/lut_sram.sv
module lut_sram #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int TOP_ADDR = 195,
  localparam int DEPTH   = TOP_ADDR + 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(waddr) <= TOP_ADDR) cells[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) <= TOP_ADDR) ? cells[raddr] : '0;
endmodule

// File: rtl/lut_burst_loader.sv
module lut_burst_loader #(
  parameter int AW        = 8,
  parameter int MAX_WORDS = 48,
  parameter int TOP_ADDR  = 195,
  localparam int LW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          fifo_full,
  output logic          push,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] left
);
  logic          active;
  logic [AW-1:0] cur;

  assign push = active && !fifo_full && !start;
  assign addr = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      left   <= '0;
    end else if (start) begin
      active <= (int'(base) <= TOP_ADDR) && (len != '0);
      cur    <= base;
      left   <= len;
    end else if (push) begin
      cur  <= cur + 1'b1;
      left <= left - 1'b1;
      if (left == LW'(1) || int'(cur) == TOP_ADDR) active <= 1'b0;
    end
  end
endmodule

// File: rtl/lut_out_fifo.sv
module lut_out_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign full      = (fill == CW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = slots[rp];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push && !flush) slots[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/lut_access_engine.sv
module lut_access_engine
  import lut_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int MAX_WORDS  = 48,
  parameter int TOP_ADDR   = 195,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [15:0]   cmd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int LW = $clog2(MAX_WORDS + 1);

  addr_word_t    aw;
  logic          set_addr, wr_cmd, rd_cmd;
  logic [AW-1:0] base_q, wptr_q, ld_addr;
  logic [LW-1:0] len_q, ld_left;
  logic          ld_push, fifo_full;
  logic [DW-1:0] mem_rdata;

  assign aw       = addr_word_t'(cmd_data);
  assign set_addr = cmd_valid && (cmd_byte == OP_SET_ADDR);
  assign wr_cmd   = cmd_valid && (cmd_byte == OP_WR_DATA);
  assign rd_cmd   = cmd_valid && (cmd_byte == OP_RD_DATA);

  lut_ptr_ctrl #(.AW(AW), .MAX_WORDS(MAX_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set_addr(set_addr),
    .new_base(aw.base), .new_len(aw.len), .wr_step(wr_cmd),
    .base_q(base_q), .wptr_q(wptr_q), .len_q(len_q)
  );

  lut_sram #(.AW(AW), .DW(DW), .TOP_ADDR(TOP_ADDR)) u_mem (
    .clk(clk), .we(wr_cmd), .waddr(wptr_q), .wdata(DW'(cmd_data)),
    .raddr(ld_addr), .rdata(mem_rdata)
  );

  lut_burst_loader #(.AW(AW), .MAX_WORDS(MAX_WORDS), .TOP_ADDR(TOP_ADDR)) u_ld (
    .clk(clk), .rst_n(rst_n), .start(rd_cmd), .base(base_q), .len(len_q),
    .fifo_full(fifo_full), .push(ld_push), .addr(ld_addr), .left(ld_left)
  );

  lut_out_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rd_cmd), .push(ld_push),
    .push_data(mem_rdata), .full(fifo_full), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/lut_access_checks.sv
module lut_access_checks #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 48,
  parameter int TOP_ADDR  = 195,
  localparam int LW       = $clog2(MAX_WORDS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          ld_push,
  input logic [AW-1:0] ld_addr,
  input logic [LW-1:0] ld_left
);
  logic rd_now;
  assign rd_now = cmd_valid && (cmd_byte == 8'h7D);

  // R8: the head word holds while the consumer stalls
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !rd_now |=> out_valid && $stable(out_data));

  // R9: a read command empties the FIFO
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> !out_valid);

  // R6: the loader never fetches past the top of memory
  a_r6_no_past_top: assert property (@(posedge clk) disable iff (!rst_n)
    ld_push |-> int'(ld_addr) <= TOP_ADDR);

  // R7: the remaining burst never exceeds the cap
  a_r7_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ld_left) <= MAX_WORDS);

  // R11: reset leaves no valid word
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind lut_access_engine lut_access_checks #(
  .AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS), .TOP_ADDR(TOP_ADDR)
) u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ld_push(ld_push), .ld_addr(ld_addr), .ld_left(ld_left)
);

// File: tb/sim_lut_access_engine.sv
module sim_lut_access_engine;
  localparam int TOP = 195;
  localparam int MAXW = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic [15:0] cmd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] model [TOP+1];

  always #2.5 clk = ~clk;

  lut_access_engine #(.FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_data(cmd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int base, input int len);
    int c;
    c = (len == 0 || len > MAXW) ? MAXW : len;
    if (base > TOP) return 0;
    return (c < TOP - base + 1) ? c : TOP - base + 1;
  endfunction

  task automatic send(input logic [7:0] b, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input int base, input int len);
    send(8'h7A, {8'(len), 8'(base)});
  endtask

  task automatic wr_word(inout int ptr, input logic [15:0] w);
    send(8'h7C, w);
    if (ptr <= TOP) model[ptr] = w;
    ptr = (ptr + 1) % 256;
  endtask

  // drains n words starting at base, then checks that nothing else follows
  task automatic collect(input int base, input int n, input string req);
    int got = 0;
    int spin = 0;
    bit stalled = 0;
    logic [15:0] held = '0;
    while (got < n && spin < 3000) begin
      @(negedge clk);
      if (stalled) check(out_valid && out_data == held, "R8 hold", int'(out_data), int'(held));
      out_ready = ($urandom % 4) != 0;
      stalled = 0;
      if (out_valid) begin
        if (out_ready) begin
          check(out_data == model[base + got], req, int'(out_data), int'(model[base + got]));
          got++;
        end else begin
          stalled = 1; held = out_data;
        end
      end
      spin++;
    end
    check(got == n, {req, " count"}, got, n);
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!out_valid, {req, " end of burst"}, int'(out_valid), 0);
    end
    out_ready = 1'b0;
  endtask

  task automatic burst(input int base, input int len, input string req);
    set_addr(base, len);
    send(8'h7D, 16'h0);
    collect(base, exp_len(base, len), req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int ptr;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(!out_valid, "R11 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R11 idle", int'(out_valid), 0);

    // R1 R2: fill all memory with auto-increment, after a length of 1 (R4)
    set_addr(0, 1);
    ptr = 0;
    for (int a = 0; a <= TOP; a++) wr_word(ptr, 16'(a * 16'h0101 ^ 16'h5A3C));
    burst(0, 48, "R5 full burst from 00h");
    burst(8'h30, 5, "R1 base and length");
    burst(8'hC0, 4, "R5 setup words");

    // R4: length field is ignored by writes
    set_addr(8'h60, 2);
    ptr = 8'h60;
    for (int i = 0; i < 6; i++) wr_word(ptr, 16'(16'hB000 + i));
    burst(8'h60, 6, "R4 writes past length");

    // R3: writes above top are dropped, no wrap into low memory
    set_addr(8'hC2, 0);
    ptr = 8'hC2;
    for (int i = 0; i < 3; i++) wr_word(ptr, 16'(16'hE000 + i));
    burst(8'hC2, 3, "R6 top cut");
    burst(0, 1, "R3 low memory untouched");
    burst(8'hB8, 30, "R3 near top");

    // R6: base above top yields nothing
    burst(8'hC4, 5, "R6 base above top");
    burst(8'hFF, 48, "R6 base ff");

    // R7: length 0 and above 48
    burst(8'h10, 0, "R7 length zero");
    burst(8'h20, 200, "R7 length large");
    burst(8'h90, 49, "R7 length 49");

    // R10: read leaves pointer and base alone
    set_addr(8'h40, 2);
    ptr = 8'h40;
    wr_word(ptr, 16'h1234);
    send(8'h7D, 16'h0);
    collect(8'h40, 2, "R10 first read");
    wr_word(ptr, 16'h4321);
    send(8'h7D, 16'h0);
    collect(8'h40, 2, "R10 pointer kept");

    // R9: restart mid-burst
    begin
      int taken = 0;
      set_addr(8'h05, 40);
      send(8'h7D, 16'h0);
      while (taken < 3) begin
        @(negedge clk);
        out_ready = 1'b1;
        if (out_valid) taken++;
      end
      @(negedge clk);
      out_ready = 1'b0;
      set_addr(8'h70, 7);
      send(8'h7D, 16'h0);
      collect(8'h70, 7, "R9 restart");
    end

    // random mix of writes and bursts
    for (int it = 0; it < 40; it++) begin
      int b, k;
      b = $urandom % 200;
      k = 1 + $urandom % 8;
      set_addr(b, $urandom % 256);
      ptr = b;
      for (int i = 0; i < k; i++) wr_word(ptr, 16'($urandom));
      b = $urandom % 204;
      k = $urandom % 64;
      burst(b, k, "R5 random burst");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule